// File: doc/BRIEF.md
# SPI Master/Slave Byte Shift Engine

This block moves one byte at a time across an SPI link in full duplex. As bus master it builds the serial clock from the system clock at one of eight rates. It shifts a byte out on the master data output and, in the same transfer, collects a byte from the master data input. As slave it follows an external serial clock and an active-low select. It returns its own byte on the slave data output while it gathers the byte on the slave data input. One shifter serves both roles. The received byte is copied into a separate read buffer when the transfer completes, so the shifter is free for the next byte at once.

Clock polarity sets the idle level of the serial clock. Clock phase chooses which of the two clock edges samples data and which one changes it. All four combinations work in both roles. Bits move most significant first. Only the rising edge of the system clock is used. The external clock, select and slave data input are sampled through a synchronizer. No pin is tri-stated: the clock and master data outputs come with a clock output enable, and the slave data output comes with its own enable.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and `rx_data_o` is 0. With `master_en_i`=1, `sck_o` equals `cpol_i`.
- R2: In master mode the half period of the serial clock is 2^(`rate_i`+1) system cycles, so the codes 0..7 give system clock /4, /8, ... /512. `done_o` is high in the cycle that starts 16·2^(`rate_i`+1) system cycles after the rising edge that accepts `start_i`.
- R3: `sck_o` rests at `cpol_i` whenever no master transfer is running. A master transfer makes exactly 16 clock transitions (8 pulses) and ends at the idle level.
- R4: Bits leave MSB first. With `cpha_i`=0 the first bit is on the data output before the first clock edge, data is sampled on leading edges (away from idle) and changed on trailing edges. With `cpha_i`=1 data changes on leading edges and is sampled on trailing edges.
- R5: The byte collected MSB first from the data input is written to `rx_data_o` once the 8th bit is sampled. It then holds until the next completed transfer.
- R6: `done_o` is a one-cycle pulse. `busy_o` is high from the accepted start (master) or the detected select fall (slave) until the cycle in which `done_o` rises.
- R7: `start_i` is ignored while a transfer runs and whenever `master_en_i`=0. `tx_data_i` is captured only when a transfer begins, and later changes to it do not alter the outgoing byte.
- R8: In slave mode a transfer begins when `ss_ni` falls. `si_i` is sampled on the edges selected by `cpha_i` and `cpol_i`, and `so_o` carries the captured transmit byte. `done_o` fires after the 8th sampling edge. The receive path works with an external clock as fast as one quarter of the system clock, and `so_o` changes within three system cycles of its shifting edge.
- R9: If `ss_ni` rises before the 8th sampling edge, the slave transfer is dropped. `done_o` stays low, `rx_data_o` keeps its old value and `busy_o` returns to 0.
- R10: `sck_oe_o` follows `master_en_i`. `so_oe_o` is 1 only in slave mode while the synchronized select is low, which is at most three system cycles after `ss_ni` changes. `mo_o` is 0 in slave mode, and the two enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | 1 selects master role, 0 selects slave role |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing edge |
| rate_i | input | RATE_W | Master clock rate code, divider 2^(code+2) |
| start_i | input | 1 | Master transfer start strobe |
| tx_data_i | input | DATA_W | Byte to transmit, captured at transfer begin |
| mi_i | input | 1 | Master serial data input |
| si_i | input | 1 | Slave serial data input |
| sck_i | input | 1 | External serial clock (slave role) |
| ss_ni | input | 1 | Slave select, active low |
| rx_data_o | output | DATA_W | Read buffer holding the last received byte |
| done_o | output | 1 | One-cycle transfer completion pulse |
| busy_o | output | 1 | Transfer in progress |
| mo_o | output | 1 | Master serial data output |
| so_o | output | 1 | Slave serial data output |
| sck_o | output | 1 | Generated serial clock |
| sck_oe_o | output | 1 | Enable for `sck_o` and `mo_o` |
| so_oe_o | output | 1 | Enable for `so_o` |

## Verification
The bench uses the default build: an 8-bit byte, a 3-bit rate code and a two-stage synchronizer. This makes every divider from /4 to /512 reachable, so the cycle count of each master transfer can be compared with the rate formula. The two-stage depth fixes the slave edge latency at three cycles. That latency lets the bench drive the external clock at one quarter of the system clock for the receive path, and at one eighth where it also checks the slave output bits.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_M_RUN  = 2'd1,
    ST_S_RUN  = 2'd2,
    ST_S_WAIT = 2'd3
  } xfer_state_e;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int CNT_W = (1 << RATE_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // half period = 2^(rate+1) cycles
  always_comb lim = (CNT_W'(2) << rate_i) - CNT_W'(1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              sample_i,
  input  logic              in_bit_i,
  input  logic              shift_i,
  output logic              out_bit_o,
  output logic              last_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              open_w;

  assign open_w = (cnt_q != CNT_W'(DATA_W));
  assign last_o = sample_i && (cnt_q == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q   <= '0;
      cnt_q     <= '0;
      out_bit_o <= 1'b0;
      rx_o      <= '0;
    end else if (load_i) begin
      shreg_q   <= load_data_i;
      cnt_q     <= '0;
      out_bit_o <= load_data_i[DATA_W-1];
    end else begin
      if (sample_i && open_w) begin
        shreg_q <= {shreg_q[DATA_W-2:0], in_bit_i};
        cnt_q   <= cnt_q + CNT_W'(1);
        if (last_o) rx_o <= {shreg_q[DATA_W-2:0], in_bit_i};
      end
      // sampled bits enter at the bottom; top bit is next to drive
      if (shift_i && open_w) out_bit_o <= shreg_q[DATA_W-1];
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_en_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              mi_i,
  input  logic              si_i,
  input  logic              sck_i,
  input  logic              ss_ni,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              mo_o,
  output logic              so_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              so_oe_o
);
  localparam int EDGE_W    = $clog2(2 * DATA_W);
  localparam int LAST_EDGE = 2 * DATA_W - 1;

  xfer_state_e       state_q;
  logic              sck_q;
  logic [EDGE_W-1:0] edge_q;
  logic              done_q;

  logic m_tick, m_lead, m_sample, m_shift;
  logic s_lvl_sck, s_rise, s_fall;
  logic ss_lvl, ss_rise, ss_fall;
  logic s_lead, s_trail, s_act, s_sample, s_shift;
  logic [SYNC_STAGES-1:0] si_dly_q;
  logic start_ok, s_begin, load, sample, shift, in_bit, out_bit, last;

  spi_rate_gen #(.RATE_W(RATE_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_M_RUN),
    .rate_i (rate_i),
    .tick_o (m_tick)
  );

  spi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sck_i),
    .level_o (s_lvl_sck),
    .rise_o  (s_rise),
    .fall_o  (s_fall)
  );

  spi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ss_ni),
    .level_o (ss_lvl),
    .rise_o  (ss_rise),
    .fall_o  (ss_fall)
  );

  // data path delayed to match the clock synchronizer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) si_dly_q <= '0;
    else         si_dly_q <= {si_dly_q[SYNC_STAGES-2:0], si_i};
  end

  // master edge decode: even edge index = leading
  assign m_lead   = ~edge_q[0];
  assign m_sample = m_tick &  (m_lead ^ cpha_i);
  assign m_shift  = m_tick & ~(m_lead ^ cpha_i);

  // slave edge decode
  assign s_lead   = cpol_i ? s_fall : s_rise;
  assign s_trail  = cpol_i ? s_rise : s_fall;
  assign s_act    = (state_q == ST_S_RUN) && !ss_lvl && !master_en_i;
  assign s_sample = s_act && (cpha_i ? s_trail : s_lead);
  assign s_shift  = s_act && (cpha_i ? s_lead : s_trail);

  assign start_ok = (state_q == ST_IDLE) && master_en_i && start_i;
  assign s_begin  = (state_q == ST_IDLE) && !master_en_i && ss_fall;
  assign load     = start_ok || s_begin;
  assign sample   = m_sample || s_sample;
  assign shift    = m_shift || s_shift;
  assign in_bit   = master_en_i ? mi_i : si_dly_q[SYNC_STAGES-1];

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (tx_data_i),
    .sample_i    (sample),
    .in_bit_i    (in_bit),
    .shift_i     (shift),
    .out_bit_o   (out_bit),
    .last_o      (last),
    .rx_o        (rx_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      edge_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_q <= ST_M_RUN;
            sck_q   <= cpol_i;
            edge_q  <= '0;
          end else if (s_begin) begin
            state_q <= ST_S_RUN;
          end
        end
        ST_M_RUN: begin
          if (!master_en_i) begin
            state_q <= ST_IDLE;
          end else if (m_tick) begin
            sck_q  <= ~sck_q;
            edge_q <= edge_q + EDGE_W'(1);
            if (edge_q == EDGE_W'(LAST_EDGE)) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_S_RUN: begin
          if (master_en_i || ss_lvl) begin
            state_q <= ST_IDLE;
          end else if (last) begin
            done_q  <= 1'b1;
            state_q <= ST_S_WAIT;
          end
        end
        ST_S_WAIT: begin
          if (master_en_i || ss_lvl) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign busy_o   = (state_q == ST_M_RUN) || (state_q == ST_S_RUN);
  assign sck_o    = (state_q == ST_M_RUN) ? sck_q : cpol_i;
  assign sck_oe_o = master_en_i;
  assign mo_o     = master_en_i & out_bit;
  assign so_o     = ~master_en_i & out_bit;
  assign so_oe_o  = ~master_en_i & ~ss_lvl;
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpol_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              done_o,
  input logic              busy_o,
  input logic              mo_o,
  input logic              sck_o,
  input logic              sck_oe_o,
  input logic              so_oe_o
);
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_busy_ends_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r3_sck_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sck_o == cpol_i));

  a_r5_rx_written_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> $past(busy_o));

  a_r4_mo_moves_with_sck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_oe_o && $stable(sck_oe_o) && busy_o && $past(busy_o) && $stable(sck_o))
      |-> $stable(mo_o));

  a_r10_one_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sck_oe_o && so_oe_o));
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cpol_i    (cpol_i),
  .rx_data_o (rx_data_o),
  .done_o    (done_o),
  .busy_o    (busy_o),
  .mo_o      (mo_o),
  .sck_o     (sck_o),
  .sck_oe_o  (sck_oe_o),
  .so_oe_o   (so_oe_o)
);

// File: tb/spi_xfer_engine_bench.sv
module spi_xfer_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       master_en_i = 1'b1;
  logic       cpol_i = 1'b0;
  logic       cpha_i = 1'b0;
  logic [2:0] rate_i = '0;
  logic       start_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       mi_i = 1'b0;
  logic       si_i = 1'b0;
  logic       sck_i = 1'b0;
  logic       ss_ni = 1'b1;
  logic [7:0] rx_data_o;
  logic       done_o, busy_o, mo_o, so_o, sck_o, sck_oe_o, so_oe_o;

  int n_checks = 0;
  int n_fail   = 0;
  int done_seen = 0;
  logic [7:0] rx_cap = '0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  spi_xfer_engine u_spi_xfer_engine (
    .clk_i, .rst_ni, .master_en_i, .cpol_i, .cpha_i, .rate_i, .start_i,
    .tx_data_i, .mi_i, .si_i, .sck_i, .ss_ni, .rx_data_o, .done_o, .busy_o,
    .mo_o, .so_o, .sck_o, .sck_oe_o, .so_oe_o
  );

  always @(negedge clk_i) if (done_o) begin
    done_seen++;
    rx_cap = rx_data_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_cycles(input int rate);
    return 16 * (2 << rate) + 1;  // seen at the negedge count after the start edge
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic m_xfer(input bit pol, input bit pha, input int rate,
                        input logic [7:0] tx, input logic [7:0] sl);
    int cyc, k, ns;
    bit prev, busy_ok, lead;
    logic [7:0] rec;
    master_en_i = 1'b1; cpol_i = pol; cpha_i = pha; rate_i = 3'(rate);
    tx_data_i = tx; mi_i = pha ? 1'b0 : sl[7];
    @(negedge clk_i);
    check(sck_o == pol, "R3 idle sck", sck_o, pol);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    tx_data_i = ~tx;  // R7: must not reach the line
    cyc = 1; k = 0; ns = 0; prev = pol; busy_ok = 1'b1; rec = '0;
    forever begin
      if (sck_o != prev) begin
        k++; prev = sck_o; lead = k[0];
        if (lead ^ pha) begin
          if (ns < 8) rec[7-ns] = mo_o;
          ns++;
        end else if (ns < 8) begin
          mi_i = sl[7-ns];
        end
      end
      if (done_o) break;
      if (!busy_o) busy_ok = 1'b0;
      if (cyc > 20000) break;
      if (cyc == 3) start_i = 1'b1;  // R7: start while busy
      if (cyc == 4) start_i = 1'b0;
      @(negedge clk_i);
      cyc++;
    end
    check(cyc == exp_cycles(rate), "R2 transfer length", cyc, exp_cycles(rate));
    check(k == 16, "R3 clock transitions", k, 16);
    check(rec == tx, "R4 R7 mo bits MSB first", rec, tx);
    check(rx_data_o == sl, "R5 received byte", rx_data_o, sl);
    check(busy_ok && !busy_o, "R6 busy window", busy_o, 0);
    @(negedge clk_i);
    check(done_o == 1'b0, "R6 done one cycle", done_o, 0);
    check(sck_o == pol && rx_data_o == sl, "R3 R5 idle after", rx_data_o, sl);
  endtask

  task automatic s_xfer(input bit pol, input bit pha, input int half,
                        input logic [7:0] tx, input logic [7:0] m,
                        input bit chk_so, input int nbits);
    int d0;
    logic [7:0] rx0, rec;
    master_en_i = 1'b0; cpol_i = pol; cpha_i = pha;
    sck_i = pol; ss_ni = 1'b1; tx_data_i = tx; si_i = m[7]; rec = '0;
    repeat (4) @(negedge clk_i);
    d0 = done_seen; rx0 = rx_data_o;
    ss_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    check(so_oe_o == 1'b1 && sck_oe_o == 1'b0, "R10 slave enables", so_oe_o, 1);
    check(busy_o == 1'b1 && mo_o == 1'b0, "R6 R10 slave busy, mo quiet", busy_o, 1);
    tx_data_i = ~tx;  // R7
    for (int i = 0; i < nbits; i++) begin
      if (!pha) rec[7-i] = so_o;
      sck_i = ~pol;
      if (pha) si_i = m[7-i];
      repeat (half) @(negedge clk_i);
      if (pha) rec[7-i] = so_o;
      sck_i = pol;
      if (!pha && i < 7) si_i = m[6-i];
      repeat (half) @(negedge clk_i);
    end
    if (nbits < 8) begin
      ss_ni = 1'b1;
      repeat (6) @(negedge clk_i);
      check(done_seen == d0, "R9 no done on abort", done_seen - d0, 0);
      check(rx_data_o == rx0, "R9 rx kept on abort", rx_data_o, rx0);
      check(busy_o == 1'b0, "R9 busy cleared", busy_o, 0);
    end else begin
      repeat (4) @(negedge clk_i);
      check(done_seen == d0 + 1, "R8 one done", done_seen - d0, 1);
      check(rx_cap == m, "R8 slave received byte", rx_cap, m);
      if (chk_so) check(rec == tx, "R8 so bits MSB first", rec, tx);
      check(busy_o == 1'b0, "R6 slave busy low", busy_o, 0);
      ss_ni = 1'b1;
      repeat (4) @(negedge clk_i);
      check(so_oe_o == 1'b0, "R10 so_oe after select", so_oe_o, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1f3c);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 0 && done_o == 0, "R1 reset flags", {busy_o, done_o}, 0);
    check(rx_data_o == 8'h00, "R1 reset rx", rx_data_o, 0);
    check(sck_o == 1'b0 && sck_oe_o == 1'b1, "R1 R10 reset sck", sck_o, 0);

    // directed: fastest and slowest rates, all formats
    m_xfer(0, 0, 0, 8'hA5, 8'h3C);
    m_xfer(0, 1, 0, 8'h81, 8'h7E);
    m_xfer(1, 0, 1, 8'h01, 8'h80);
    m_xfer(1, 1, 7, 8'hFF, 8'h00);

    // R7: start ignored in slave mode
    master_en_i = 1'b0; cpol_i = 1'b1;
    @(negedge clk_i); start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(busy_o == 0 && sck_o == 1'b1 && sck_oe_o == 0, "R7 start ignored in slave",
          busy_o, 0);

    // slave directed
    s_xfer(0, 0, 4, 8'hC3, 8'h5A, 1, 8);
    s_xfer(1, 1, 4, 8'h12, 8'hED, 1, 8);
    s_xfer(0, 1, 2, 8'h6B, 8'h94, 0, 8);  // R8 external clock at sysclk/4
    s_xfer(1, 0, 2, 8'h2D, 8'hB1, 0, 8);
    s_xfer(0, 0, 4, 8'h77, 8'h11, 0, 3);  // R9 abort

    // random mix
    for (int i = 0; i < 20; i++) begin
      logic [31:0] r;
      r = $urandom();
      m_xfer(r[0], r[1], int'(r[4:2]), 8'($urandom()), 8'($urandom()));
    end
    for (int i = 0; i < 16; i++) begin
      logic [31:0] r;
      r = $urandom();
      s_xfer(r[0], r[1], 4 + int'(r[3:2]), 8'($urandom()), 8'($urandom()), 1, 8);
    end
    finish_run();
  end
endmodule